// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block merges level-sensitive interrupt requests from a set of devices onto a small number of shared interrupt outputs. Every device contributes four request pins. Each pin is steered to one shared line by a fixed rotation that spreads device pins evenly over the lines.

For each shared line the block keeps a running count of how many of its sources are currently asserted. The block does not OR the inputs. It remembers the last level seen on every source pin and only adjusts a counter when a pin actually changes. A rise adds one and a fall subtracts one. A shared line is driven high while its count is nonzero. The counts are also brought out, so the surrounding logic can see how many requests share each line.

All source changes seen at one clock edge are applied together. Simultaneous rises and falls on the same line are therefore netted in a single update, and none of them is lost.

Top module: `irq_line_aggregator`

## Requirements
- R1: The request input is a flat vector with four pins per device; device d, pin p sits at bit d*4+p of `req_i`.
- R2: The block stores the last sampled level of every source pin; at a clock edge where a pin's level equals its stored level, that pin leaves every counter unchanged.
- R3: At each clock edge the counter of the mapped line is incremented by one for every source that rose and decremented by one for every source that fell, so after the edge it equals the number of its mapped sources that were high at that edge.
- R4: Output `line_o[i]` is high exactly when counter i is nonzero; both reflect the inputs sampled at the previous clock edge (one cycle of latency).
- R5: Device d, pin p is routed to shared line (p + d) mod NUM_LINES.
- R6: When several sources change at the same edge, all of their increments and decrements are applied at that edge, including a rise and a fall that cancel on one line.
- R7: Synchronous active-high reset clears all counters, all outputs and all stored levels; a pin that is high when reset is released counts as a rise at the first edge after release.
- R8: `cnt_o` packs counter i into bits [i*CW +: CW], where CW = clog2(NUM_DEV*4+1), wide enough for every source being asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_DEV*4 | Device request levels, bit d*4+p is device d pin p |
| line_o | output | NUM_LINES | Shared interrupt line levels |
| cnt_o | output | NUM_LINES*CW | Per-line asserted-source counts, line i at [i*CW +: CW] |

## Verification
Directed patterns come first. A single pin on one device shows that the rotation picks the right line. With every pin high, each line reaches its full count of one source per device. A rise and a fall on the same line at one edge must leave its count unchanged, which would expose a serialized or dropped update. Holding a pattern for several cycles shows that unchanged levels do not creep the counts. A reset taken while requests are high, and released with them still high, checks that stale levels are cleared and then recounted. Sparse random toggling of a few bits per cycle then exercises mixed rises and falls across all lines at once.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int PINS_PER_DEV = 4;

    typedef enum logic [1:0] {
        LVL_HOLD = 2'b00,
        LVL_RISE = 2'b01,
        LVL_FALL = 2'b10
    } lvl_ev_e;

    // Classify one source pin from its stored and new level.
    function automatic lvl_ev_e classify(input logic old_lvl, input logic new_lvl);
        if (old_lvl == new_lvl) return LVL_HOLD;
        else if (new_lvl)       return LVL_RISE;
        else                    return LVL_FALL;
    endfunction

    // Rotation routing: flat source index -> shared line number.
    function automatic int line_of(input int src, input int nlines);
        return ((src % PINS_PER_DEV) + (src / PINS_PER_DEV)) % nlines;
    endfunction

    function automatic int cnt_width(input int total_src);
        return $clog2(total_src + 1);
    endfunction

endpackage

// File: rtl/irq_level_tracker.sv
module irq_level_tracker
    import irq_agg_pkg::*;
#(
    parameter int TOTAL = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TOTAL-1:0] req_i,
    output logic [TOTAL-1:0] rise_o,
    output logic [TOTAL-1:0] fall_o
);

    logic [TOTAL-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) last_q <= '0;
        else     last_q <= req_i;
    end

    always_comb begin
        for (int k = 0; k < TOTAL; k++) begin
            lvl_ev_e ev;
            ev        = classify(last_q[k], req_i[k]);
            rise_o[k] = (ev == LVL_RISE);
            fall_o[k] = (ev == LVL_FALL);
        end
    end

endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter
    import irq_agg_pkg::*;
#(
    parameter int TOTAL     = 16,
    parameter int NUM_LINES = 4,
    parameter int LINE      = 0,
    parameter int CW        = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TOTAL-1:0] rise_i,
    input  logic [TOTAL-1:0] fall_i,
    output logic [CW-1:0]    cnt_o
);

    logic [CW-1:0] up_n;
    logic [CW-1:0] dn_n;
    logic [CW-1:0] cnt_q;

    // Net every change routed to this line in one pass.
    always_comb begin
        up_n = '0;
        dn_n = '0;
        for (int k = 0; k < TOTAL; k++) begin
            if (line_of(k, NUM_LINES) == LINE) begin
                if (rise_i[k]) up_n = up_n + CW'(1);
                if (fall_i[k]) dn_n = dn_n + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + up_n - dn_n;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/irq_line_aggregator.sv
module irq_line_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_DEV   = 4,
    parameter int NUM_LINES = 4,
    localparam int TOTAL    = NUM_DEV * PINS_PER_DEV,
    localparam int CW       = cnt_width(NUM_DEV * PINS_PER_DEV)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [TOTAL-1:0]        req_i,
    output logic [NUM_LINES-1:0]    line_o,
    output logic [NUM_LINES*CW-1:0] cnt_o
);

    logic [TOTAL-1:0] rise_w;
    logic [TOTAL-1:0] fall_w;

    irq_level_tracker #(.TOTAL(TOTAL)) u_track (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req_i),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic [CW-1:0] cnt_w;

        irq_line_counter #(
            .TOTAL     (TOTAL),
            .NUM_LINES (NUM_LINES),
            .LINE      (i),
            .CW        (CW)
        ) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .rise_i (rise_w),
            .fall_i (fall_w),
            .cnt_o  (cnt_w)
        );

        assign cnt_o[i*CW +: CW] = cnt_w;
        assign line_o[i]         = |cnt_w;
    end

endmodule

// File: rtl/irq_line_aggregator_chk.sv
module irq_line_aggregator_chk
    import irq_agg_pkg::*;
#(
    parameter int NUM_DEV   = 4,
    parameter int NUM_LINES = 4,
    localparam int TOTAL    = NUM_DEV * PINS_PER_DEV,
    localparam int CW       = cnt_width(NUM_DEV * PINS_PER_DEV)
) (
    input logic                    clk,
    input logic                    rst,
    input logic [TOTAL-1:0]        req_i,
    input logic [NUM_LINES-1:0]    line_o,
    input logic [NUM_LINES*CW-1:0] cnt_o
);

    logic                    pv_q   = 1'b0;
    logic                    rst_q  = 1'b0;
    logic [TOTAL-1:0]        req_q  = '0;
    logic [NUM_LINES*CW-1:0] exp_cnt;
    logic [NUM_LINES-1:0]    exp_line;
    int                      cnt_sum;

    always_ff @(posedge clk) begin
        pv_q  <= !rst;
        rst_q <= rst;
        req_q <= req_i;
    end

    always_comb begin
        exp_cnt = '0;
        for (int k = 0; k < TOTAL; k++) begin
            if (req_q[k])
                exp_cnt[line_of(k, NUM_LINES)*CW +: CW] =
                    exp_cnt[line_of(k, NUM_LINES)*CW +: CW] + CW'(1);
        end
        cnt_sum = 0;
        for (int i = 0; i < NUM_LINES; i++) begin
            exp_line[i] = |exp_cnt[i*CW +: CW];
            cnt_sum     = cnt_sum + int'(cnt_o[i*CW +: CW]);
        end
    end

    // R2: no level change seen at an edge leaves every count as it was
    p_hold_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (pv_q && req_i == req_q) |=> $stable(cnt_o));

    // R3: total of all counts equals number of sources high at the last edge
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        pv_q |-> (cnt_sum == $countones(req_q)));

    // R5, R6: each count equals its rotated sources high at the last edge
    p_route_r5: assert property (@(posedge clk) disable iff (rst)
        pv_q |-> (cnt_o == exp_cnt));

    // R4: line levels follow nonzero counts of the mapped sources
    p_line_level_r4: assert property (@(posedge clk) disable iff (rst)
        pv_q |-> (line_o == exp_line));

    // R7: one edge after reset everything reads zero
    always @(posedge clk) begin
        if (rst_q) begin
            p_reset_clear_r7: assert (cnt_o == '0 && line_o == '0);
        end
    end

endmodule

bind irq_line_aggregator irq_line_aggregator_chk #(
    .NUM_DEV   (NUM_DEV),
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req_i),
    .line_o (line_o),
    .cnt_o  (cnt_o)
);

// File: tb/irq_line_aggregator_tb.sv
module irq_line_aggregator_tb;

    localparam int NUM_DEV   = 4;
    localparam int NUM_LINES = 4;
    localparam int T         = NUM_DEV * 4;
    localparam int CW        = $clog2(T + 1);

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [T-1:0]            req_i = '0;
    logic [NUM_LINES-1:0]    line_o;
    logic [NUM_LINES*CW-1:0] cnt_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_line_aggregator #(.NUM_DEV(NUM_DEV), .NUM_LINES(NUM_LINES)) u_dut (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req_i),
        .line_o (line_o),
        .cnt_o  (cnt_o)
    );

    // Expected count: sources d*4+p high with (p+d) mod NUM_LINES == line (R1, R5)
    function automatic int exp_cnt(input logic [T-1:0] v, input int line);
        int n = 0;
        for (int d = 0; d < NUM_DEV; d++)
            for (int p = 0; p < 4; p++)
                if (v[d*4+p] && ((p + d) % NUM_LINES) == line) n++;
        return n;
    endfunction

    task automatic check_all(input logic [T-1:0] v, input string tag);
        for (int l = 0; l < NUM_LINES; l++) begin
            int got = int'(cnt_o[l*CW +: CW]);
            int exp = exp_cnt(v, l);
            checks++;
            if (got != exp) begin
                errors++;
                $display("FAIL %s R3/R8 line %0d count actual=%0d expected=%0d", tag, l, got, exp);
            end
            checks++;
            if (line_o[l] != (exp != 0)) begin
                errors++;
                $display("FAIL %s R4 line %0d level actual=%0b expected=%0b", tag, l, line_o[l], exp != 0);
            end
        end
    endtask

    // Apply at a falling edge, check at the next falling edge.
    task automatic step(input logic [T-1:0] v, input string tag);
        req_i = v;
        @(negedge clk);
        check_all(v, tag);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [T-1:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R7: reset state
        check_all('0, "R7 reset");
        rst = 1'b0;

        step('0, "R2 idle");
        // R5: device 1 pin 2 -> line 3
        step(T'(1) << (1*4+2), "R5 single");
        // R5: device 3 pin 3 -> line 2
        step(T'(1) << (3*4+3), "R5 wrap");
        // R3: all sources high
        step('1, "R3 all high");
        step('1, "R2 hold all");
        step('0, "R3 all low");
        // R6: dev0 pin0 (line0) up, dev1 pin3 (line0) down at the same edge
        step(T'(1) << (1*4+3), "R6 prep");
        step(T'(1) << 0, "R6 cancel");
        // R6: many simultaneous rises across lines
        step(T'(16'hA5C3), "R6 multi");
        // R2: hold pattern several cycles
        for (int i = 0; i < 4; i++) step(T'(16'hA5C3), "R2 hold");

        // R7: reset while requests high, release with them still high
        req_i = T'(16'h0F0F);
        rst = 1'b1;
        @(negedge clk);
        check_all('0, "R7 in reset");
        rst = 1'b0;
        @(negedge clk);
        check_all(T'(16'h0F0F), "R7 recount");

        // Sparse random toggles, R3/R6
        v = T'(16'h0F0F);
        for (int i = 0; i < 300; i++) begin
            v = v ^ (T'($urandom) & T'($urandom) & T'($urandom));
            step(v, "R6 random");
        end
        finish_run();
    end

endmodule